// File: doc/BRIEF.md
# Network Interrupt Receive Router

This block sits behind a ring receiver that has already decoded network interrupt packets. Each packet brings a sender node ID, a destination node ID, a broadcast flag, a 3-bit kind code and a 32-bit payload. The router decides whether the local node is addressed. It then sends the packet to one of four user interrupt lanes, or handles it as a reset-node request.

Each user lane holds two FIFOs of equal depth. One stores payload words and the other stores sender IDs. An accepted packet pushes into both FIFOs of its lane in the same cycle. A lane whose payload FIFO holds data raises its pending line toward the interrupt aggregator. A reset-node request only sets a sticky status line. Acting on that request is left to software. Software pops either FIFO of any lane through a small read port, and can flush a lane.

A state machine handles one packet per cycle. It has four states:
- ST_IDLE: nothing to do.
- ST_DELIVER: push the latched packet into its lane.
- ST_RSTREQ: set the reset-request flag.
- ST_DISCARD: drop the packet. This covers packets that are not addressed to this node and packets with unused kind codes.

The next state is chosen from the packet on the input in the current cycle. Every state can move to every state:
- With no valid packet, the next state is ST_IDLE.
- A valid packet that is not addressed, or that carries kind 5 to 7, leads to ST_DISCARD.
- An addressed packet of kind 0 leads to ST_RSTREQ.
- An addressed packet of kind 1 to 4 leads to ST_DELIVER.

Top module: `netint_rx_router`

## Requirements
- R1: A valid packet is accepted only when `pkt_dst` equals `node_id` or `pkt_bcast` is 1; any other packet changes no output.
- R2: Kind code 0 is a reset-node request and kinds 1, 2, 3, 4 select user lanes 0, 1, 2, 3. Kinds 5, 6 and 7 are ignored: no pending, overflow or reset-request output changes.
- R3: An accepted user packet pushes its payload into the lane's data FIFO and its sender ID into the lane's ID FIFO. Both FIFOs return entries in arrival order.
- R4: An accepted reset-node request sets `reset_request`. The flag stays set until `status_clr[4]` is 1 for a cycle, and the request stores nothing in any FIFO.
- R5: A user packet whose lane data or ID FIFO is full is dropped and sets `irq_overflow[lane]`. That flag stays set until `status_clr[lane]` is 1 for a cycle.
- R6: `irq_pending[lane]` is 1 exactly when the lane's data FIFO is not empty. It rises after the second rising edge that follows the edge where the packet was presented.
- R7: With `rd_en` high, `rd_type` picks the lane and `rd_id` picks the FIFO (0 for data, 1 for sender ID). After that edge, `rd_data` holds the oldest entry (an ID is zero-extended) and the entry is removed. A read of an empty FIFO returns 0 and changes nothing.
- R8: `flush_en` with `flush_type` empties both FIFOs of that lane at the edge. A push into the same lane at that edge is discarded and does not set overflow.
- R9: After reset, all pending, overflow and reset-request outputs and `rd_data` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| node_id | input | ID_W | Local node ID |
| pkt_valid | input | 1 | Packet present this cycle |
| pkt_src | input | ID_W | Sender node ID |
| pkt_dst | input | ID_W | Destination node ID |
| pkt_bcast | input | 1 | Broadcast flag |
| pkt_kind | input | KIND_W | Interrupt kind code |
| pkt_data | input | DATA_W | User payload |
| rd_en | input | 1 | Pop request |
| rd_type | input | LANE_W | Lane to read |
| rd_id | input | 1 | 1 reads the sender-ID FIFO, 0 reads the data FIFO |
| rd_data | output | DATA_W | Value popped by the previous read |
| flush_en | input | 1 | Flush request |
| flush_type | input | LANE_W | Lane to flush |
| status_clr | input | NUM_LANES+1 | Clear mask: bits for lane overflow flags, top bit for reset request |
| irq_pending | output | NUM_LANES | Per-lane pending lines |
| irq_overflow | output | NUM_LANES | Per-lane sticky overflow flags |
| reset_request | output | 1 | Sticky reset-node request flag |

## Verification
The bench builds the router with a FIFO depth of 4 and keeps the 8-bit IDs and 32-bit payload. With that depth, every lane can be filled and overflowed in a few packets. The bench then sweeps the full and wrap-around behaviour of all four lanes. It also sweeps every kind code and a set of destination and broadcast combinations against a fixed node ID. Payloads and sender IDs follow an arithmetic pattern per lane, so the bench can predict each popped value directly.

// File: rtl/netint_pkg.sv
package netint_pkg;

    localparam int NUM_LANES = 4;
    localparam int KIND_W    = 3;

    localparam logic [KIND_W-1:0] KIND_RESET_REQ = '0;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_DELIVER,
        ST_RSTREQ,
        ST_DISCARD
    } rx_state_e;

endpackage

// File: rtl/netint_fifo.sv
module netint_fifo #(
    parameter int W     = 32,
    parameter int DEPTH = 127
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         flush,
    input  logic         push,
    input  logic [W-1:0] wdata,
    input  logic         pop,
    output logic [W-1:0] head,
    output logic         empty,
    output logic         full
);

    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);
    localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);
    localparam logic [CW-1:0] CMAX = CW'(DEPTH);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wptr, rptr;
    logic [CW-1:0] cnt;
    logic          do_push, do_pop;

    function automatic logic [AW-1:0] step(input logic [AW-1:0] p);
        return (p == LAST) ? '0 : p + 1'b1;
    endfunction

    assign empty   = (cnt == '0);
    assign full    = (cnt == CMAX);
    assign do_push = push && !full && !flush;
    assign do_pop  = pop && !empty && !flush;
    assign head    = mem[rptr];

    always_ff @(posedge clk) begin
        if (do_push) begin
            mem[wptr] <= wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            wptr <= '0;
            rptr <= '0;
            cnt  <= '0;
        end else begin
            if (do_push) begin
                wptr <= step(wptr);
            end
            if (do_pop) begin
                rptr <= step(rptr);
            end
            if (do_push && !do_pop) begin
                cnt <= cnt + 1'b1;
            end else if (do_pop && !do_push) begin
                cnt <= cnt - 1'b1;
            end
        end
    end

endmodule

// File: rtl/netint_lane.sv
module netint_lane #(
    parameter int DATA_W = 32,
    parameter int ID_W   = 8,
    parameter int DEPTH  = 127
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push,
    input  logic [ID_W-1:0]   src,
    input  logic [DATA_W-1:0] data,
    input  logic              pop_data,
    input  logic              pop_id,
    input  logic              flush,
    input  logic              ovf_clr,
    output logic [DATA_W-1:0] head_data,
    output logic [ID_W-1:0]   head_id,
    output logic              data_empty,
    output logic              id_empty,
    output logic              ovf
);

    logic data_full, id_full, room, dropped;

    assign room    = !data_full && !id_full;
    assign dropped = push && !room && !flush;

    netint_fifo #(.W(DATA_W), .DEPTH(DEPTH)) u_data_fifo (
        .clk   (clk),
        .rst_n (rst_n),
        .flush (flush),
        .push  (push && room),
        .wdata (data),
        .pop   (pop_data),
        .head  (head_data),
        .empty (data_empty),
        .full  (data_full)
    );

    netint_fifo #(.W(ID_W), .DEPTH(DEPTH)) u_id_fifo (
        .clk   (clk),
        .rst_n (rst_n),
        .flush (flush),
        .push  (push && room),
        .wdata (src),
        .pop   (pop_id),
        .head  (head_id),
        .empty (id_empty),
        .full  (id_full)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ovf <= 1'b0;
        end else if (dropped) begin
            ovf <= 1'b1;
        end else if (ovf_clr) begin
            ovf <= 1'b0;
        end
    end

endmodule

// File: rtl/netint_rx_fsm.sv
module netint_rx_fsm
    import netint_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int ID_W   = 8,
    parameter int LANES  = NUM_LANES,
    parameter int KW     = KIND_W,
    localparam int LW    = (LANES > 1) ? $clog2(LANES) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ID_W-1:0]   node_id,
    input  logic              pkt_valid,
    input  logic [ID_W-1:0]   pkt_src,
    input  logic [ID_W-1:0]   pkt_dst,
    input  logic              pkt_bcast,
    input  logic [KW-1:0]     pkt_kind,
    input  logic [DATA_W-1:0] pkt_data,
    output logic              deliver,
    output logic [LW-1:0]     deliver_lane,
    output logic [ID_W-1:0]   deliver_src,
    output logic [DATA_W-1:0] deliver_data,
    output logic              rst_req_set
);

    rx_state_e state, state_nx;
    logic      addressed, is_user, is_reset;

    assign addressed = pkt_bcast || (pkt_dst == node_id);
    assign is_reset  = (pkt_kind == KIND_RESET_REQ);
    assign is_user   = (pkt_kind != KIND_RESET_REQ) && (int'(pkt_kind) <= LANES);

    always_comb begin
        state_nx = ST_IDLE;
        if (pkt_valid) begin
            if (!addressed) begin
                state_nx = ST_DISCARD;
            end else if (is_reset) begin
                state_nx = ST_RSTREQ;
            end else if (is_user) begin
                state_nx = ST_DELIVER;
            end else begin
                state_nx = ST_DISCARD;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= state_nx;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            deliver_lane <= '0;
            deliver_src  <= '0;
            deliver_data <= '0;
        end else if (pkt_valid) begin
            deliver_lane <= LW'(pkt_kind - 1'b1);
            deliver_src  <= pkt_src;
            deliver_data <= pkt_data;
        end
    end

    always_comb begin
        deliver     = 1'b0;
        rst_req_set = 1'b0;
        unique case (state)
            ST_IDLE:    ;
            ST_DELIVER: deliver = 1'b1;
            ST_RSTREQ:  rst_req_set = 1'b1;
            ST_DISCARD: ;
            default:    ;
        endcase
    end

endmodule

// File: rtl/netint_rx_router.sv
module netint_rx_router
    import netint_pkg::*;
#(
    parameter int DATA_W     = 32,
    parameter int ID_W       = 8,
    parameter int FIFO_DEPTH = 127,
    parameter int LANES      = NUM_LANES,
    parameter int KW         = KIND_W,
    localparam int LW        = (LANES > 1) ? $clog2(LANES) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ID_W-1:0]   node_id,
    input  logic              pkt_valid,
    input  logic [ID_W-1:0]   pkt_src,
    input  logic [ID_W-1:0]   pkt_dst,
    input  logic              pkt_bcast,
    input  logic [KW-1:0]     pkt_kind,
    input  logic [DATA_W-1:0] pkt_data,
    input  logic              rd_en,
    input  logic [LW-1:0]     rd_type,
    input  logic              rd_id,
    output logic [DATA_W-1:0] rd_data,
    input  logic              flush_en,
    input  logic [LW-1:0]     flush_type,
    input  logic [LANES:0]    status_clr,
    output logic [LANES-1:0]  irq_pending,
    output logic [LANES-1:0]  irq_overflow,
    output logic              reset_request
);

    logic              deliver, rst_req_set;
    logic [LW-1:0]     deliver_lane;
    logic [ID_W-1:0]   deliver_src;
    logic [DATA_W-1:0] deliver_data;

    logic [DATA_W-1:0] head_data [LANES];
    logic [ID_W-1:0]   head_id   [LANES];
    logic [LANES-1:0]  data_empty, id_empty;

    netint_rx_fsm #(
        .DATA_W (DATA_W),
        .ID_W   (ID_W),
        .LANES  (LANES),
        .KW     (KW)
    ) u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .node_id      (node_id),
        .pkt_valid    (pkt_valid),
        .pkt_src      (pkt_src),
        .pkt_dst      (pkt_dst),
        .pkt_bcast    (pkt_bcast),
        .pkt_kind     (pkt_kind),
        .pkt_data     (pkt_data),
        .deliver      (deliver),
        .deliver_lane (deliver_lane),
        .deliver_src  (deliver_src),
        .deliver_data (deliver_data),
        .rst_req_set  (rst_req_set)
    );

    for (genvar t = 0; t < LANES; t++) begin : g_lane
        netint_lane #(
            .DATA_W (DATA_W),
            .ID_W   (ID_W),
            .DEPTH  (FIFO_DEPTH)
        ) u_lane (
            .clk        (clk),
            .rst_n      (rst_n),
            .push       (deliver && (deliver_lane == LW'(t))),
            .src        (deliver_src),
            .data       (deliver_data),
            .pop_data   (rd_en && !rd_id && (rd_type == LW'(t))),
            .pop_id     (rd_en && rd_id && (rd_type == LW'(t))),
            .flush      (flush_en && (flush_type == LW'(t))),
            .ovf_clr    (status_clr[t]),
            .head_data  (head_data[t]),
            .head_id    (head_id[t]),
            .data_empty (data_empty[t]),
            .id_empty   (id_empty[t]),
            .ovf        (irq_overflow[t])
        );
    end

    assign irq_pending = ~data_empty;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            reset_request <= 1'b0;
        end else if (rst_req_set) begin
            reset_request <= 1'b1;
        end else if (status_clr[LANES]) begin
            reset_request <= 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_data <= '0;
        end else if (rd_en) begin
            if (rd_id) begin
                rd_data <= id_empty[rd_type] ? '0 : DATA_W'(head_id[rd_type]);
            end else begin
                rd_data <= data_empty[rd_type] ? '0 : head_data[rd_type];
            end
        end
    end

endmodule

// File: rtl/netint_rx_chk.sv
module netint_rx_chk #(
    parameter int LANES = 4,
    parameter int KW    = 3,
    parameter int LW    = 2
) (
    input logic             clk,
    input logic             rst_n,
    input logic             pkt_valid,
    input logic [KW-1:0]    pkt_kind,
    input logic             rd_en,
    input logic             flush_en,
    input logic [LW-1:0]    flush_type,
    input logic [LANES:0]   status_clr,
    input logic [LANES-1:0] irq_pending,
    input logic [LANES-1:0] irq_overflow,
    input logic             reset_request
);

    for (genvar k = 0; k < LANES; k++) begin : g_chk
        AST_PEND_NEEDS_PKT: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(irq_pending[k]) |-> $past(pkt_valid, 2)); // R6
        AST_PEND_FALL_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(irq_pending[k]) |-> ($past(rd_en) || $past(flush_en))); // R7
        AST_OVF_NEEDS_PKT: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(irq_overflow[k]) |-> $past(pkt_valid, 2)); // R5
        AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
            (irq_overflow[k] && !status_clr[k]) |=> irq_overflow[k]); // R5
        AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
            (flush_en && (flush_type == LW'(k))) |=> !irq_pending[k]); // R8
    end

    AST_RSTREQ_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(reset_request) |-> ($past(pkt_valid, 2) && ($past(pkt_kind, 2) == '0))); // R4
    AST_RSTREQ_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (reset_request && !status_clr[LANES]) |=> reset_request); // R4

endmodule

bind netint_rx_router netint_rx_chk #(
    .LANES (LANES),
    .KW    (KW),
    .LW    (LW)
) u_netint_rx_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .pkt_valid     (pkt_valid),
    .pkt_kind      (pkt_kind),
    .rd_en         (rd_en),
    .flush_en      (flush_en),
    .flush_type    (flush_type),
    .status_clr    (status_clr),
    .irq_pending   (irq_pending),
    .irq_overflow  (irq_overflow),
    .reset_request (reset_request)
);

// File: tb/test_netint_rx_router.sv
`timescale 1ns/1ps
module test_netint_rx_router;

    localparam int DEPTH = 4;
    localparam int LANES = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  node_id = 8'h5A;
    logic        pkt_valid = 1'b0;
    logic [7:0]  pkt_src = '0;
    logic [7:0]  pkt_dst = '0;
    logic        pkt_bcast = 1'b0;
    logic [2:0]  pkt_kind = '0;
    logic [31:0] pkt_data = '0;
    logic        rd_en = 1'b0;
    logic [1:0]  rd_type = '0;
    logic        rd_id = 1'b0;
    logic [31:0] rd_data;
    logic        flush_en = 1'b0;
    logic [1:0]  flush_type = '0;
    logic [4:0]  status_clr = '0;
    logic [3:0]  irq_pending, irq_overflow;
    logic        reset_request;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    netint_rx_router #(.FIFO_DEPTH(DEPTH)) i_netint_rx_router (
        .clk(clk), .rst_n(rst_n), .node_id(node_id),
        .pkt_valid(pkt_valid), .pkt_src(pkt_src), .pkt_dst(pkt_dst),
        .pkt_bcast(pkt_bcast), .pkt_kind(pkt_kind), .pkt_data(pkt_data),
        .rd_en(rd_en), .rd_type(rd_type), .rd_id(rd_id), .rd_data(rd_data),
        .flush_en(flush_en), .flush_type(flush_type), .status_clr(status_clr),
        .irq_pending(irq_pending), .irq_overflow(irq_overflow),
        .reset_request(reset_request)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic send(input logic [2:0] kind, input logic [7:0] src,
                        input logic [7:0] dst, input logic bc, input logic [31:0] d);
        @(negedge clk);
        pkt_valid = 1'b1; pkt_kind = kind; pkt_src = src;
        pkt_dst = dst; pkt_bcast = bc; pkt_data = d;
        @(negedge clk);
        pkt_valid = 1'b0;
    endtask

    task automatic pop(input logic [1:0] t, input logic id, output logic [31:0] v);
        @(negedge clk);
        rd_en = 1'b1; rd_type = t; rd_id = id;
        @(negedge clk);
        rd_en = 1'b0;
        v = rd_data;
    endtask

    task automatic clr(input logic [4:0] m);
        @(negedge clk);
        status_clr = m;
        @(negedge clk);
        status_clr = '0;
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        #(4 * 150000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=done");
            finish_run();
        end
    end

    initial begin
        logic [31:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R9 reset state
        chk("R9 pending", {28'd0, irq_pending}, 32'd0);
        chk("R9 overflow", {28'd0, irq_overflow}, 32'd0);
        chk("R9 reset_request", {31'd0, reset_request}, 32'd0);
        chk("R9 rd_data", rd_data, 32'd0);

        // R1 addressing sweep
        begin
            logic [7:0] dsts [5] = '{8'h5A, 8'h5B, 8'h00, 8'hFF, 8'hA5};
            for (int i = 0; i < 5; i++) begin
                for (int b = 0; b < 2; b++) begin
                    logic acc;
                    acc = (dsts[i] == 8'h5A) || (b == 1);
                    send(3'd1, 8'(i + 16 * b), dsts[i], 1'(b), 32'hA000_0000 + 32'(i * 2 + b));
                    @(negedge clk);
                    chk("R1 accept", {31'd0, irq_pending[0]}, {31'd0, acc});
                    chk("R1 others", {29'd0, irq_pending[3:1]}, 32'd0);
                    if (acc) begin
                        pop(2'd0, 1'b0, v);
                        chk("R1 data", v, 32'hA000_0000 + 32'(i * 2 + b));
                        pop(2'd0, 1'b1, v);
                        chk("R1 id", v, 32'(i + 16 * b));
                    end
                end
            end
        end

        // R2/R4 kind sweep
        for (int k = 0; k < 8; k++) begin
            logic [3:0] exp_p;
            exp_p = (k >= 1 && k <= 4) ? 4'(1 << (k - 1)) : 4'd0;
            @(negedge clk);
            pkt_valid = 1'b1; pkt_kind = 3'(k); pkt_dst = 8'h5A; pkt_bcast = 1'b0;
            pkt_src = 8'(k); pkt_data = 32'(k * 7);
            @(negedge clk);
            pkt_valid = 1'b0;
            // R6 latency: not yet visible one edge after presentation
            chk("R6 latency", {28'd0, irq_pending}, 32'd0);
            @(negedge clk);
            chk("R2 lane", {28'd0, irq_pending}, {28'd0, exp_p});
            chk("R4 reset flag", {31'd0, reset_request}, {31'd0, (k == 0)});
            chk("R2 no overflow", {28'd0, irq_overflow}, 32'd0);
            if (k >= 1 && k <= 4) begin
                pop(2'(k - 1), 1'b0, v);
                chk("R2 data", v, 32'(k * 7));
                pop(2'(k - 1), 1'b1, v);
            end
            if (k == 0) begin
                clr(5'b10000);
                chk("R4 cleared", {31'd0, reset_request}, 32'd0);
            end
        end

        // R3/R5/R6/R7 per lane fill and overflow
        for (int t = 0; t < LANES; t++) begin
            for (int i = 0; i <= DEPTH; i++) begin
                send(3'(t + 1), 8'(16 * t + i), 8'h00, 1'b1, 32'h1000_0000 * t + 32'(i * 3 + 1));
            end
            @(negedge clk);
            chk("R5 overflow bit", {28'd0, irq_overflow}, 32'(1 << t));
            chk("R6 pending full", {28'd0, irq_pending}, 32'(1 << t));
            for (int i = 0; i < DEPTH; i++) begin
                pop(2'(t), 1'b0, v);
                chk("R3 data order", v, 32'h1000_0000 * t + 32'(i * 3 + 1));
            end
            chk("R6 pending drained", {28'd0, irq_pending}, 32'd0);
            for (int i = 0; i < DEPTH; i++) begin
                pop(2'(t), 1'b1, v);
                chk("R3 id order", v, 32'(16 * t + i));
            end
            pop(2'(t), 1'b0, v);
            chk("R7 empty data read", v, 32'd0);
            pop(2'(t), 1'b1, v);
            chk("R7 empty id read", v, 32'd0);
            clr(5'(1 << t));
            chk("R5 overflow cleared", {28'd0, irq_overflow}, 32'd0);
        end

        // R3 wrap: second fill after pointers wrapped
        for (int i = 0; i < 3; i++) begin
            send(3'd2, 8'(200 + i), 8'h5A, 1'b0, 32'(i + 90));
        end
        for (int i = 0; i < 3; i++) begin
            pop(2'd1, 1'b0, v);
            chk("R3 wrap data", v, 32'(i + 90));
        end
        for (int i = 0; i < 3; i++) begin
            pop(2'd1, 1'b1, v);
            chk("R3 wrap id", v, 32'(200 + i));
        end

        // R8 flush
        send(3'd3, 8'h11, 8'h5A, 1'b0, 32'h55);
        send(3'd3, 8'h12, 8'h5A, 1'b0, 32'h66);
        @(negedge clk);
        chk("R8 before flush", {31'd0, irq_pending[2]}, 32'd1);
        @(negedge clk);
        flush_en = 1'b1; flush_type = 2'd2;
        @(negedge clk);
        flush_en = 1'b0;
        chk("R8 flushed pending", {28'd0, irq_pending}, 32'd0);
        pop(2'd2, 1'b1, v);
        chk("R8 flushed id", v, 32'd0);

        // R8 flush beats push in the same cycle
        @(negedge clk);
        pkt_valid = 1'b1; pkt_kind = 3'd2; pkt_dst = 8'h5A; pkt_bcast = 1'b0;
        pkt_src = 8'h33; pkt_data = 32'h77;
        @(negedge clk);
        pkt_valid = 1'b0;
        flush_en = 1'b1; flush_type = 2'd1;
        @(negedge clk);
        flush_en = 1'b0;
        chk("R8 push discarded", {28'd0, irq_pending}, 32'd0);
        chk("R8 no overflow", {28'd0, irq_overflow}, 32'd0);

        done = 1'b1;
        finish_run();
    end

endmodule